// File: doc/BRIEF.md
# Quarter-Rate IQ Demodulator

This block turns a single stream of signed 14-bit samples of an intermediate-frequency RF signal into baseband in-phase (I) and quadrature (Q) values. The sample clock runs at exactly four times the IF (for example 81.024 MHz for a 20.256 MHz IF). With that ratio, the cosine and sine references take only the values +1, 0 and −1. The mixer therefore needs no multiplier. It becomes a router that sends every other sample to the I path or the Q path, together with a sign that alternates within each path. Each path runs at half the sample rate.

A two-bit phase counter steps once per accepted sample and sets both the route and the sign. Each path then passes through its own moving-average low-pass filter over the last 2^N values that reached it. The filter keeps a running sum and a circular delay line, and divides with an arithmetic right shift. After every phase-3 sample, once the delay lines have filled, the block presents one I/Q pair on a valid/ready output.

Back-pressure works as follows. The output holds its pair until it is taken. While a pair waits untaken, the input stops accepting samples, so no sample is ever dropped and the phase never slips.

Top module: `iq_demod_top`

## Requirements
- R1: A sample is consumed on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is low exactly when `m_valid` is high and `m_ready` is low.
- R2: The phase counter starts at 0, advances by one per consumed sample and wraps from 3 to 0. Routing by phase: phase 0 sends +x to I, phase 1 sends +x to Q, phase 2 sends −x to I, and phase 3 sends −x to Q.
- R3: Negating the most negative sample (−8192) yields +8191 instead of wrapping.
- R4: Each output value is the sum of the last 2^N values that entered that path, arithmetically shifted right by N (floor division). Delay-line slots not yet written since reset count as zero.
- R5: `m_valid` rises on the edge that consumes a phase-3 sample. This happens only for the 2^(N-1)-th and later phase-3 samples since reset, and never at any other time.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_i` and `m_q` hold their values.
- R7: A synchronous reset clears the phase counter, the running sums, the delay lines, the fill count and `m_valid`.
- R8: `m_i` and `m_q` are clamped to the signed OUT_W-bit range. Values above the range give the maximum and values below it give the minimum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, four times the IF |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input sample present |
| s_ready | output | 1 | Block can consume a sample this cycle |
| s_data | input | DATA_W | Signed ADC sample |
| m_valid | output | 1 | I/Q pair present |
| m_ready | input | 1 | Consumer takes the pair this cycle |
| m_i | output | OUT_W | Filtered in-phase value, signed |
| m_q | output | OUT_W | Filtered quadrature value, signed |

## Verification
The bench builds the block with N=2 and OUT_W=12. A four-deep delay line per path means the first pair appears on the second phase-3 sample, so the fill boundary is reached within a few cycles of every reset. A 12-bit output is narrower than the average of full-scale 14-bit samples, so both clamp limits can be reached, one of them through the saturated negation of −8192. Random input gaps and random output stalls exercise the hold and stall rules against a behavioural queue model.

// File: rtl/iq_demod_pkg.sv
package iq_demod_pkg;
  typedef enum logic [1:0] {
    PH_I_POS = 2'd0,
    PH_Q_POS = 2'd1,
    PH_I_NEG = 2'd2,
    PH_Q_NEG = 2'd3
  } phase_e;
endpackage

// File: rtl/iq_phase_mux.sv
module iq_phase_mux
  import iq_demod_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take,
  input  logic signed [DW-1:0] din,
  output phase_e               phase,
  output logic                 i_en,
  output logic                 q_en,
  output logic                 frame_end,
  output logic signed [DW-1:0] dout
);
  localparam logic signed [DW-1:0] MIN_V = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] MAX_V = {1'b0, {(DW-1){1'b1}}};

  logic signed [DW-1:0] neg_v;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_I_POS;
    else if (take) phase <= phase_e'(2'(phase + 2'd1));
  end

  // saturating negation: -MIN would wrap back to MIN
  always_comb begin
    if (din == MIN_V) neg_v = MAX_V;
    else              neg_v = -din;
  end

  always_comb begin
    dout      = phase[1] ? neg_v : din;
    i_en      = take && !phase[0];
    q_en      = take &&  phase[0];
    frame_end = take && (phase == PH_Q_NEG);
  end
endmodule

// File: rtl/iq_mavg.sv
module iq_mavg #(
  parameter int DW = 14,
  parameter int N  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic signed [DW-1:0]   din,
  output logic signed [DW+N-1:0] sum_now
);
  localparam int D  = 1 << N;
  localparam int SW = DW + N;

  logic signed [DW-1:0] line_q [D];
  logic [N-1:0]         wp;
  logic signed [SW-1:0] sum_q;
  logic signed [SW-1:0] sum_d;
  logic signed [DW-1:0] oldest;

  always_comb begin
    oldest  = line_q[wp];
    sum_d   = sum_q + {{N{din[DW-1]}}, din} - {{N{oldest[DW-1]}}, oldest};
    sum_now = en ? sum_d : sum_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < D; k++) line_q[k] <= '0;
      wp    <= '0;
      sum_q <= '0;
    end else if (en) begin
      line_q[wp] <= din;
      wp         <= wp + 1'b1;
      sum_q      <= sum_d;
    end
  end
endmodule

// File: rtl/iq_out_stage.sv
module iq_out_stage #(
  parameter int SW = 16,
  parameter int OW = 14,
  parameter int N  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_end,
  input  logic signed [SW-1:0] sum_i,
  input  logic signed [SW-1:0] sum_q,
  input  logic                 m_ready,
  output logic                 m_valid,
  output logic signed [OW-1:0] m_i,
  output logic signed [OW-1:0] m_q
);
  localparam int FILL = 1 << (N - 1);
  localparam int CW   = $clog2(FILL) + 1;
  localparam logic signed [SW-1:0] HI = {{(SW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [SW-1:0] LO = {{(SW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic [CW-1:0] fill_q;
  logic          emit;

  function automatic logic signed [OW-1:0] scale_clamp(input logic signed [SW-1:0] s);
    logic signed [SW-1:0] sh;
    sh = s >>> N;
    if (sh > HI)      return HI[OW-1:0];
    else if (sh < LO) return LO[OW-1:0];
    else              return sh[OW-1:0];
  endfunction

  assign emit = frame_end && (fill_q == CW'(FILL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q  <= '0;
      m_valid <= 1'b0;
      m_i     <= '0;
      m_q     <= '0;
    end else begin
      if (frame_end && !emit) fill_q <= fill_q + 1'b1;
      if (emit) begin
        m_valid <= 1'b1;
        m_i     <= scale_clamp(sum_i);
        m_q     <= scale_clamp(sum_q);
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/iq_demod_top.sv
module iq_demod_top
  import iq_demod_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int N      = 2,
  parameter int OUT_W  = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic signed [DATA_W-1:0] s_data,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic signed [OUT_W-1:0]  m_i,
  output logic signed [OUT_W-1:0]  m_q
);
  localparam int SW = DATA_W + N;

  phase_e                    phase_w;
  logic                      take, i_en, q_en, frame_end;
  logic signed [DATA_W-1:0]  path_v;
  logic signed [SW-1:0]      sum_i, sum_q;

  assign s_ready = !(m_valid && !m_ready);
  assign take    = s_valid && s_ready;

  iq_phase_mux #(.DW(DATA_W)) u_mux (
    .clk(clk), .rst(rst), .take(take), .din(s_data),
    .phase(phase_w), .i_en(i_en), .q_en(q_en),
    .frame_end(frame_end), .dout(path_v)
  );

  iq_mavg #(.DW(DATA_W), .N(N)) u_lpf_i (
    .clk(clk), .rst(rst), .en(i_en), .din(path_v), .sum_now(sum_i)
  );

  iq_mavg #(.DW(DATA_W), .N(N)) u_lpf_q (
    .clk(clk), .rst(rst), .en(q_en), .din(path_v), .sum_now(sum_q)
  );

  iq_out_stage #(.SW(SW), .OW(OUT_W), .N(N)) u_out (
    .clk(clk), .rst(rst), .frame_end(frame_end),
    .sum_i(sum_i), .sum_q(sum_q), .m_ready(m_ready),
    .m_valid(m_valid), .m_i(m_i), .m_q(m_q)
  );
endmodule

// File: rtl/iq_demod_chk.sv
module iq_demod_chk #(
  parameter int OW = 14
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 s_valid,
  input logic                 s_ready,
  input logic                 m_valid,
  input logic                 m_ready,
  input logic signed [OW-1:0] m_i,
  input logic signed [OW-1:0] m_q,
  input logic [1:0]           phase
);
  p_reset_clears_r7: assert property (@(posedge clk)
    rst |=> (!m_valid && phase == 2'd0));

  p_stall_r1: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |-> !s_ready);

  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> phase == 2'($past(phase) + 2'd1));

  p_phase_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !(s_valid && s_ready) |=> $stable(phase));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_i) && $stable(m_q)));

  p_emit_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> $past(s_valid && s_ready && phase == 2'd3));
endmodule

bind iq_demod_top iq_demod_chk #(.OW(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q),
  .phase(phase_w)
);

// File: tb/iq_demod_top_tb_top.sv
module iq_demod_top_tb_top;
  localparam int DW = 14;
  localparam int NN = 2;
  localparam int OW = 12;
  localparam int DEPTH = 1 << NN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0;
  logic m_ready = 1'b1;
  logic s_ready, m_valid;
  logic signed [DW-1:0] s_data = '0;
  logic signed [OW-1:0] m_i, m_q;

  int checks = 0;
  int errors = 0;
  string cur_req = "R4";

  int qi[$];
  int qq[$];
  int ph, frames;
  bit exp_mv, held;
  int exp_i, exp_q;

  always #10 clk = ~clk;

  iq_demod_top #(.DATA_W(DW), .N(NN), .OUT_W(OW)) dut_i (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q)
  );

  task automatic fail(input string req, input string what, input int act, input int expv);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
  endtask

  function automatic int clampv(input int v);
    int hi = (1 << (OW - 1)) - 1;
    int lo = -(1 << (OW - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic int qsum(input int q[$]);
    int s = 0;
    foreach (q[k]) s += q[k];
    return s;
  endfunction

  task automatic model_reset();
    qi.delete(); qq.delete();
    for (int k = 0; k < DEPTH; k++) begin qi.push_back(0); qq.push_back(0); end
    ph = 0; frames = 0; exp_mv = 0; held = 0; exp_i = 0; exp_q = 0;
  endtask

  task automatic check_out();
    string dreq;
    dreq = held ? "R6" : cur_req;
    checks++;
    if (m_valid !== exp_mv) fail("R5", "m_valid", int'(m_valid), int'(exp_mv));
    if (exp_mv) begin
      checks++;
      if (int'(m_i) != exp_i) fail(dreq, "m_i", int'(m_i), exp_i);
      checks++;
      if (int'(m_q) != exp_q) fail(dreq, "m_q", int'(m_q), exp_q);
    end
  endtask

  task automatic step(input bit v, input int x, input bit rdy);
    bit er, nmv;
    int pv;
    @(negedge clk);
    check_out();
    s_valid = v; s_data = DW'(x); m_ready = rdy;
    er = !(exp_mv && !rdy);
    #1;
    checks++;
    if (s_ready !== er) fail("R1", "s_ready", int'(s_ready), int'(er));
    nmv = exp_mv && !rdy;
    held = exp_mv && !rdy;
    if (v && er) begin
      if (ph >= 2) pv = (x == -8192) ? 8191 : -x;
      else pv = x;
      if (ph % 2 == 0) begin qi.push_back(pv); void'(qi.pop_front()); end
      else begin qq.push_back(pv); void'(qq.pop_front()); end
      if (ph == 3) begin
        frames++;
        if (frames >= DEPTH / 2) begin
          nmv = 1;
          exp_i = clampv(qsum(qi) >>> NN);
          exp_q = clampv(qsum(qq) >>> NN);
        end
      end
      ph = (ph + 1) % 4;
    end
    exp_mv = nmv;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; s_valid = 0; m_ready = 1;
    model_reset();
    @(negedge clk);
    rst = 0;
    #1;
    checks++;
    if (m_valid !== 1'b0) fail("R7", "m_valid after reset", int'(m_valid), 0);
    checks++;
    if (s_ready !== 1'b1) fail("R7", "s_ready after reset", int'(s_ready), 1);
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int pat[4];
    model_reset();
    do_reset();

    // R2: impulses on each phase show route and sign
    cur_req = "R2";
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 8; k++) step(1, (k == p) ? 1000 + 200 * p : 0, 1);
    end

    // R4: random samples with input gaps
    cur_req = "R4";
    for (int k = 0; k < 200; k++)
      step(($urandom_range(0, 3) != 0), int'($urandom_range(0, 16383)) - 8192, 1);

    // R3: most negative value on every phase
    cur_req = "R3";
    for (int k = 0; k < 24; k++) step(1, -8192, 1);

    // R8: full-scale patterns that exceed the 12-bit output range
    cur_req = "R8";
    pat = '{8191, 0, -8192, 0};
    for (int k = 0; k < 16; k++) step(1, pat[k % 4], 1);
    pat = '{-8192, 0, 8191, 0};
    for (int k = 0; k < 16; k++) step(1, pat[k % 4], 1);

    // R6: random output stalls
    cur_req = "R6";
    for (int k = 0; k < 300; k++)
      step(($urandom_range(0, 4) != 0), int'($urandom_range(0, 16383)) - 8192,
           $urandom_range(0, 1) == 1);

    // R7: reset in mid-stream, then R5 fill timing again
    cur_req = "R7";
    for (int k = 0; k < 5; k++) step(1, 3000 - 100 * k, 1);
    do_reset();
    cur_req = "R5";
    for (int k = 0; k < 20; k++) step(1, 50 * k - 400, 1);
    step(0, 0, 1);
    step(0, 0, 1);
    finish_run();
  end
endmodule